// File: doc/BRIEF.md
# Multiplexed Bidirectional Latch Bus Exchanger

This block connects one narrow port (A) to two banks (B1 and B2) of the same width. Each direction has its own pair of level-sensitive storage latches. From B toward A, each bank loads its own latch, and a select input decides which stored word drives A. From A toward B, the A word loads two independent latches, one per bank. Software-free bank control comes from the separate output enables, so one A stream can be split across two memory banks, and two bank streams can be merged back onto A.

The block has no clock. A latch follows its input while its enable is high. When the enable falls, the latch keeps the value it had at that moment, and it holds that value until the enable rises again.

Each pin group is modelled as three signals: an input bus, an output bus, and a drive flag that is high when the port drives. An active-low asynchronous reset clears all four latches.

Top module: `mux_latch_exchanger`

## Requirements
- R1: While `rst_n` is low, all four latches hold zero. With all latch enables low after reset, every enabled output bus reads zero.
- R2: With `sel` = 1 and `le_b1` = 1, `a_out` follows `b1_in` in the same cycle.
- R3: With `sel` = 0 and `le_b2` = 1, `a_out` follows `b2_in` in the same cycle.
- R4: When a latch enable falls, the latch keeps its last value. Later changes on that latch's input bus do not reach the output while the enable stays low.
- R5: With `oe_a_n` = 1, `a_oe` is 0 and `a_out` is all zeros, whatever the other inputs are. With `oe_a_n` = 0, `a_oe` is 1.
- R6: While `le_a1` is high, `b1_out` follows `a_in`. The `le_a2` input has no effect on the B1 latch.
- R7: While `le_a2` is high, `b2_out` follows `a_in`. The `le_a1` input has no effect on the B2 latch.
- R8: `oe_b1_n` and `oe_b2_n` are independent. A low level on either one sets that bank's drive flag and shows its latch on its output bus. A high level gives a flag of 0 and an output of zero. Both banks, one bank, or neither may drive.
- R9: Toggling `sel` while both B-side latches hold switches `a_out` between the two stored words and does not change either stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of all latches |
| a_in | input | 12 | Word arriving on the A pins |
| a_out | output | 12 | Word driven onto the A pins |
| a_oe | output | 1 | High when the A pins are driven |
| b1_in | input | 12 | Word arriving on bank B1 |
| b1_out | output | 12 | Word driven onto bank B1 |
| b1_oe | output | 1 | High when bank B1 is driven |
| b2_in | input | 12 | Word arriving on bank B2 |
| b2_out | output | 12 | Word driven onto bank B2 |
| b2_oe | output | 1 | High when bank B2 is driven |
| sel | input | 1 | 1 routes the B1 latch to A, 0 routes the B2 latch |
| le_b1 | input | 1 | Transparency enable of the B1-to-A latch |
| le_b2 | input | 1 | Transparency enable of the B2-to-A latch |
| le_a1 | input | 1 | Transparency enable of the A-to-B1 latch |
| le_a2 | input | 1 | Transparency enable of the A-to-B2 latch |
| oe_a_n | input | 1 | Active-low drive enable of the A pins |
| oe_b1_n | input | 1 | Active-low drive enable of bank B1 |
| oe_b2_n | input | 1 | Active-low drive enable of bank B2 |

## Verification
Every result is due zero cycles after its stimulus, because the whole path is latches and multiplexers. The driver changes inputs just after a rising clock edge, and the monitor compares outputs at the following falling edge, half a period later, so the logic has settled and no edge ordering matters. Hold behaviour is checked in two steps. The first step drops the enable, and the second step changes the input. The expected word for both steps comes from the bench's own copy of the stored values.

// File: rtl/mux_latch_exchanger.sv
module mux_latch_exchanger #(
  parameter int W = 12
) (
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_oe,
  input  logic         sel,
  input  logic         le_b1,
  input  logic         le_b2,
  input  logic         le_a1,
  input  logic         le_a2,
  input  logic         oe_a_n,
  input  logic         oe_b1_n,
  input  logic         oe_b2_n
);
  logic [W-1:0] up1_q, up2_q, dn1_q, dn2_q;

  always_latch
    if (!rst_n)     up1_q <= '0;
    else if (le_b1) up1_q <= b1_in;

  always_latch
    if (!rst_n)     up2_q <= '0;
    else if (le_b2) up2_q <= b2_in;

  always_latch
    if (!rst_n)     dn1_q <= '0;
    else if (le_a1) dn1_q <= a_in;

  always_latch
    if (!rst_n)     dn2_q <= '0;
    else if (le_a2) dn2_q <= a_in;

  assign a_oe   = ~oe_a_n;
  assign b1_oe  = ~oe_b1_n;
  assign b2_oe  = ~oe_b2_n;

  assign a_out  = a_oe  ? (sel ? up1_q : up2_q) : '0;
  assign b1_out = b1_oe ? dn1_q : '0;
  assign b2_out = b2_oe ? dn2_q : '0;
endmodule

module mux_latch_exchanger_chk #(
  parameter int W = 12
) (
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b1_in,
  input logic [W-1:0] b1_out,
  input logic         b1_oe,
  input logic [W-1:0] b2_in,
  input logic [W-1:0] b2_out,
  input logic         b2_oe,
  input logic         sel,
  input logic         le_b1,
  input logic         le_b2,
  input logic         le_a1,
  input logic         le_a2,
  input logic         oe_a_n,
  input logic         oe_b1_n,
  input logic         oe_b2_n
);
  always_comb begin
    // R1
    if (!rst_n && a_oe) reset_clear_chk: assert (a_out == '0);
    // R2
    if (rst_n && sel && le_b1 && a_oe) b1_to_a_flow_chk: assert (a_out == b1_in);
    // R3
    if (rst_n && !sel && le_b2 && a_oe) b2_to_a_flow_chk: assert (a_out == b2_in);
    // R5
    if (oe_a_n) a_quiet_chk: assert (!a_oe && a_out == '0);
    // R6
    if (rst_n && le_a1 && b1_oe) a_to_b1_flow_chk: assert (b1_out == a_in);
    // R7
    if (rst_n && le_a2 && b2_oe) a_to_b2_flow_chk: assert (b2_out == a_in);
    // R8
    if (oe_b1_n || oe_b2_n) b_quiet_chk: assert ((!oe_b1_n || (!b1_oe && b1_out == '0)) &&
                                                 (!oe_b2_n || (!b2_oe && b2_out == '0)));
  end
endmodule

bind mux_latch_exchanger mux_latch_exchanger_chk #(.W(W)) u_chk (.*);

// File: tb/test_mux_latch_exchanger.sv
`timescale 1ns/1ps
module test_mux_latch_exchanger;
  localparam int W = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic         sel = 1'b0, le_b1 = 1'b0, le_b2 = 1'b0, le_a1 = 1'b0, le_a2 = 1'b0;
  logic         oe_a_n = 1'b0, oe_b1_n = 1'b0, oe_b2_n = 1'b0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic         a_oe, b1_oe, b2_oe;

  mux_latch_exchanger #(.W(W)) i_mux_latch_exchanger (
    .rst_n, .a_in, .a_out, .a_oe, .b1_in, .b1_out, .b1_oe, .b2_in, .b2_out, .b2_oe,
    .sel, .le_b1, .le_b2, .le_a1, .le_a2, .oe_a_n, .oe_b1_n, .oe_b2_n);

  typedef struct {
    string        tag;
    logic [W-1:0] a, b1, b2;
    logic         ao, b1o, b2o;
  } exp_t;

  exp_t sb[$];
  int runs = 0, fails = 0;
  bit done = 1'b0;
  logic [W-1:0] m_u1 = '0, m_u2 = '0, m_d1 = '0, m_d2 = '0;

  task automatic step(input string tag);
    exp_t e;
    #1;
    if (!rst_n) begin m_u1 = '0; m_u2 = '0; m_d1 = '0; m_d2 = '0; end
    else begin
      if (le_b1) m_u1 = b1_in;
      if (le_b2) m_u2 = b2_in;
      if (le_a1) m_d1 = a_in;
      if (le_a2) m_d2 = a_in;
    end
    e.tag = tag;
    e.ao  = !oe_a_n;  e.b1o = !oe_b1_n;  e.b2o = !oe_b2_n;
    e.a   = e.ao  ? (sel ? m_u1 : m_u2) : '0;
    e.b1  = e.b1o ? m_d1 : '0;
    e.b2  = e.b2o ? m_d2 : '0;
    sb.push_back(e);
    @(posedge clk);
  endtask

  initial forever begin
    @(negedge clk);
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      runs++;
      if ({a_out, a_oe, b1_out, b1_oe, b2_out, b2_oe} !== {e.a, e.ao, e.b1, e.b1o, e.b2, e.b2o}) begin
        fails++;
        $display("FAIL %s: got a=%h/%b b1=%h/%b b2=%h/%b exp a=%h/%b b1=%h/%b b2=%h/%b",
                 e.tag, a_out, a_oe, b1_out, b1_oe, b2_out, b2_oe,
                 e.a, e.ao, e.b1, e.b1o, e.b2, e.b2o);
      end
    end
  end

  initial begin
    @(posedge clk);
    b1_in = 12'hA5A; b2_in = 12'h3C3; a_in = 12'h777; sel = 1'b1;
    step("R1 reset clears, sel=1");
    sel = 1'b0; step("R1 reset clears, sel=0");
    rst_n = 1'b1; step("R1 zero after reset release");

    sel = 1'b1; le_b1 = 1'b1; step("R2 B1 transparent");
    b1_in = 12'h123; step("R2 B1 follows change");
    le_b1 = 1'b0; step("R4 B1 latch closes");
    b1_in = 12'hFFF; step("R4 B1 holds after input change");

    sel = 1'b0; le_b2 = 1'b1; step("R3 B2 transparent");
    b2_in = 12'h0F0; step("R3 B2 follows change");
    le_b2 = 1'b0; step("R4 A freezes when le_b2 drops");
    b2_in = 12'hBEE; step("R4 B2 holds after input change");

    sel = 1'b1; step("R9 sel to held B1");
    sel = 1'b0; step("R9 sel back to held B2");
    oe_a_n = 1'b1; step("R5 A undriven");
    le_b1 = 1'b1; b1_in = 12'h456; sel = 1'b1; step("R5 A undriven while transparent");
    le_b1 = 1'b0; oe_a_n = 1'b0; step("R5 A driven again");

    le_a1 = 1'b1; a_in = 12'h9AB; step("R6 A to B1 only");
    a_in = 12'h321; step("R6 B1 follows A");
    le_a1 = 1'b0; le_a2 = 1'b1; a_in = 12'hCDE; step("R7 A to B2 only, B1 held");
    le_a2 = 1'b0; a_in = 12'h000; step("R4 both B latches hold");

    oe_b1_n = 1'b1; step("R8 only B2 drives");
    oe_b1_n = 1'b0; oe_b2_n = 1'b1; step("R8 only B1 drives");
    oe_b1_n = 1'b1; step("R8 neither drives");
    oe_b1_n = 1'b0; oe_b2_n = 1'b0; step("R8 both drive");

    rst_n = 1'b0; step("R1 reset mid-run");
    rst_n = 1'b1; step("R1 zero after second reset");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule